// File: doc/BRIEF.md
# Time-Slot Interchange Switch Core

This block is a small non-blocking TDM switch. Serial input streams are turned into 8-bit channels and written into a data memory. A connection memory holds one control word per output channel. It picks which input stream and timeslot that output channel carries, or it replaces the switched data with a fixed byte, all ones, or a released driver. The chosen bytes are sent back out as serial streams. Streams come in groups of four, and one frame holds a parameterised number of timeslots of eight bit periods each.

The data memory has three pages, one per frame in rotation. Each output channel can choose one of two delay modes. Constant delay keeps the channels of a frame together: every channel leaves exactly two frames after it arrived. Variable delay gives the lowest latency: it takes the newest byte already captured for the source slot. A frame pulse aligns all the slot counters. A global output enable releases every output driver at once, whatever the control words hold.

Top module: `tsi_switch_core`

## Requirements
- R1: When `fp_i` is high at a rising edge, the following cycle is bit period 0 of slot 0. Slot t occupies bit periods 8t to 8t+7 on both inputs and outputs, and bits are sent and received most significant first.
- R2: Routing is non-blocking. Any output channel may take any input channel, and several output channels may carry the same input channel in the same frame.
- R3: In constant-delay normal mode (bit 8 = 1, mode 00), output slot t of frame M carries the byte that the source stream received in the source slot of frame M-2.
- R4: In variable-delay normal mode (bit 8 = 0, mode 00), output slot t of frame M carries frame M's byte when t is greater than the source slot s, and frame M-1's byte otherwise.
- R5: In mode 01, the output slot carries the control word's low 8 bits in place of switched data.
- R6: In mode 10, the output slot carries all ones for the whole slot.
- R7: In mode 11, `sto_en_o` is low for that slot only. Neighbouring slots of the same stream are unaffected.
- R8: While `oe_i` is low, every bit of `sto_en_o` is low in the same cycle, whatever the control words hold.
- R9: A control word is written over `cm_we_i`/`cm_addr_i`/`cm_wdata_i`. The address is {output stream, output slot}, with the slot in the low bits. The word is {mode[10:9], constant-delay[8], payload[7:0]}. In normal mode the payload holds the source slot in its low bits and the source stream above them. A write is used from the next load of that slot onward.
- R10: After reset, `sto_en_o` and `sto_o` are all zero until the first slot load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| fp_i | input | 1 | Frame pulse, high in the last bit period of a frame |
| sti_i | input | STREAMS | Serial input streams |
| oe_i | input | 1 | Global output enable, asynchronous |
| cm_we_i | input | 1 | Connection memory write strobe |
| cm_addr_i | input | STR_W+SLOT_W | Connection memory address {stream, slot} |
| cm_wdata_i | input | 11 | Connection memory control word |
| sto_o | output | STREAMS | Serial output streams |
| sto_en_o | output | STREAMS | Per-stream output driver enable |

## Verification
An output byte is loaded at the edge that ends the slot before it, so slot t's bits are valid from cycle 8t to 8t+7 of a frame. The bench drives inputs just after each edge and samples outputs in the middle of each cycle. It builds each output byte from its eight samples and checks it at that slot's last bit period. For constant delay the expected byte is the input byte from two frames earlier. For variable delay it is the byte from the same or the previous frame, depending on t and s. The output enable is combinational, so it is checked in the same cycle that `oe_i` changes. Control words are rewritten during a frame that is not checked, so every checked frame sees one settled configuration.

// File: rtl/tsi_pkg.sv
package tsi_pkg;
  typedef enum logic [1:0] {
    MODE_NORM = 2'd0,
    MODE_MSG  = 2'd1,
    MODE_HIGH = 2'd2,
    MODE_HIZ  = 2'd3
  } ch_mode_e;

  typedef struct packed {
    ch_mode_e   mode;
    logic       const_dly;
    logic [7:0] payload;
  } cm_entry_t;

  localparam int unsigned CH_BITS = 8;
  localparam int unsigned PAGES   = 3;

  // (p - n) mod 3, p and n in 0..2
  function automatic logic [1:0] page_back(logic [1:0] p, logic [1:0] n);
    logic [2:0] sum;
    logic [2:0] red;
    sum = {1'b0, p} + 3'd3 - {1'b0, n};
    red = sum - 3'd3;
    return (sum >= 3'd3) ? red[1:0] : sum[1:0];
  endfunction
endpackage

// File: rtl/tsi_timing.sv
module tsi_timing #(
  parameter int unsigned SLOTS  = 8,
  localparam int unsigned SLOT_W = $clog2(SLOTS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fp_i,
  output logic [2:0]        bit_o,
  output logic [SLOT_W-1:0] slot_o,
  output logic [SLOT_W-1:0] next_slot_o,
  output logic              slot_end_o,
  output logic              frame_end_o,
  output logic [1:0]        page_o
);
  logic [2:0]        bit_q;
  logic [SLOT_W-1:0] slot_q;
  logic [1:0]        page_q;
  logic              last_slot;

  assign last_slot   = (slot_q == SLOT_W'(SLOTS - 1));
  assign slot_end_o  = (bit_q == 3'd7);
  assign frame_end_o = fp_i | (slot_end_o & last_slot);
  assign next_slot_o = frame_end_o ? '0 : slot_q + SLOT_W'(1);
  assign bit_o       = bit_q;
  assign slot_o      = slot_q;
  assign page_o      = page_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_q  <= '0;
      slot_q <= '0;
      page_q <= '0;
    end else if (frame_end_o) begin
      bit_q  <= '0;
      slot_q <= '0;
      page_q <= (page_q == 2'd2) ? 2'd0 : page_q + 2'd1;
    end else if (slot_end_o) begin
      bit_q  <= '0;
      slot_q <= slot_q + SLOT_W'(1);
    end else begin
      bit_q  <= bit_q + 3'd1;
    end
  end

  assert_page_range_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    page_q != 2'd3) else $error("page pointer out of range");

  assert_frame_align_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fp_i |=> (bit_o == 3'd0 && slot_o == '0)) else $error("frame pulse did not realign");

  assert_page_turn_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_end_o |=> page_o != $past(page_o)) else $error("page did not rotate");
endmodule

// File: rtl/tsi_rx.sv
module tsi_rx #(
  parameter int unsigned STREAMS = 4
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [STREAMS-1:0]     sti_i,
  output logic [STREAMS-1:0][7:0] byte_o
);
  for (genvar g = 0; g < STREAMS; g++) begin : g_lane
    logic [6:0] sh_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sh_q <= '0;
      else         sh_q <= {sh_q[5:0], sti_i[g]};
    end
    assign byte_o[g] = {sh_q, sti_i[g]};
  end
endmodule

// File: rtl/tsi_dmem.sv
module tsi_dmem #(
  parameter int unsigned STREAMS = 4,
  parameter int unsigned SLOTS   = 8,
  localparam int unsigned SLOT_W = $clog2(SLOTS),
  localparam int unsigned STR_W  = (STREAMS > 1) ? $clog2(STREAMS) : 1
) (
  input  logic                           clk_i,
  input  logic                           we_i,
  input  logic [1:0]                     wr_page_i,
  input  logic [SLOT_W-1:0]              wr_slot_i,
  input  logic [STREAMS-1:0][7:0]        wr_byte_i,
  input  logic [STREAMS-1:0][1:0]        rd_page_i,
  input  logic [STREAMS-1:0][STR_W-1:0]  rd_str_i,
  input  logic [STREAMS-1:0][SLOT_W-1:0] rd_slot_i,
  output logic [STREAMS-1:0][7:0]        rd_byte_o
);
  import tsi_pkg::*;

  logic [7:0] mem_q [PAGES][STREAMS][SLOTS];

  always_ff @(posedge clk_i) begin
    if (we_i) begin
      for (int s = 0; s < STREAMS; s++) mem_q[wr_page_i][s][wr_slot_i] <= wr_byte_i[s];
    end
  end

  // read port per output lane; same-edge write is forwarded
  for (genvar r = 0; r < STREAMS; r++) begin : g_rd
    logic hit;
    assign hit = we_i && (rd_page_i[r] == wr_page_i) && (rd_slot_i[r] == wr_slot_i);
    assign rd_byte_o[r] = hit ? wr_byte_i[rd_str_i[r]]
                              : mem_q[rd_page_i[r]][rd_str_i[r]][rd_slot_i[r]];
  end
endmodule

// File: rtl/tsi_tx_lane.sv
module tsi_tx_lane #(
  parameter int unsigned STREAMS = 4,
  parameter int unsigned SLOTS   = 8,
  localparam int unsigned SLOT_W = $clog2(SLOTS),
  localparam int unsigned STR_W  = (STREAMS > 1) ? $clog2(STREAMS) : 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                oe_i,
  input  logic                load_i,
  input  logic [SLOT_W-1:0]   next_slot_i,
  input  logic [1:0]          cur_page_i,
  input  logic [2:0]          bit_i,
  input  tsi_pkg::cm_entry_t  entry_i,
  output logic [1:0]          rd_page_o,
  output logic [STR_W-1:0]    rd_str_o,
  output logic [SLOT_W-1:0]   rd_slot_o,
  input  logic [7:0]          rd_byte_i,
  output logic                sto_o,
  output logic                sto_en_o
);
  import tsi_pkg::*;

  logic [7:0] out_q;
  logic       hiz_q;
  logic       first_slot;
  logic [1:0] back;

  assign rd_slot_o  = entry_i.payload[SLOT_W-1:0];
  assign rd_str_o   = entry_i.payload[SLOT_W +: STR_W];
  assign first_slot = (next_slot_i == '0);

  // slot 0 is loaded in the previous frame, so it is one page closer
  always_comb begin
    if (entry_i.const_dly) back = first_slot ? 2'd1 : 2'd2;
    else                   back = (first_slot || next_slot_i > rd_slot_o) ? 2'd0 : 2'd1;
  end
  assign rd_page_o = page_back(cur_page_i, back);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q <= '0;
      hiz_q <= 1'b1;
    end else if (load_i) begin
      hiz_q <= (entry_i.mode == MODE_HIZ);
      unique case (entry_i.mode)
        MODE_NORM: out_q <= rd_byte_i;
        MODE_MSG:  out_q <= entry_i.payload;
        MODE_HIGH: out_q <= 8'hFF;
        MODE_HIZ:  out_q <= out_q;
      endcase
    end
  end

  assign sto_o    = out_q[3'd7 - bit_i];
  assign sto_en_o = oe_i & ~hiz_q;

  assert_const_page_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && entry_i.const_dly && entry_i.mode == MODE_NORM) |-> rd_page_o != cur_page_i)
    else $error("constant delay read hit the page being written");

  assert_msg_byte_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && entry_i.mode == MODE_MSG) |=> out_q == $past(entry_i.payload))
    else $error("message byte not loaded");

  assert_force_high_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && entry_i.mode == MODE_HIGH) |=> (out_q == 8'hFF && !hiz_q))
    else $error("force-high slot not all ones");

  assert_slot_hiz_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && entry_i.mode == MODE_HIZ) |=> !sto_en_o)
    else $error("high-impedance slot still driven");

  assert_global_oe_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oe_i |-> !sto_en_o) else $error("driver enabled while output enable low");
endmodule

// File: rtl/tsi_switch_core.sv
module tsi_switch_core #(
  parameter int unsigned GROUPS = 1,
  parameter int unsigned SLOTS  = 8,
  localparam int unsigned STREAMS = 4 * GROUPS,
  localparam int unsigned SLOT_W  = $clog2(SLOTS),
  localparam int unsigned STR_W   = (STREAMS > 1) ? $clog2(STREAMS) : 1,
  localparam int unsigned AW      = STR_W + SLOT_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               fp_i,
  input  logic [STREAMS-1:0] sti_i,
  input  logic               oe_i,
  input  logic               cm_we_i,
  input  logic [AW-1:0]      cm_addr_i,
  input  logic [10:0]        cm_wdata_i,
  output logic [STREAMS-1:0] sto_o,
  output logic [STREAMS-1:0] sto_en_o
);
  import tsi_pkg::*;

  logic [2:0]        bit_idx;
  logic [SLOT_W-1:0] slot, next_slot;
  logic              slot_end, frame_end, load;
  logic [1:0]        page;

  logic [STREAMS-1:0][7:0]        rx_byte;
  logic [STREAMS-1:0][1:0]        rd_page;
  logic [STREAMS-1:0][STR_W-1:0]  rd_str;
  logic [STREAMS-1:0][SLOT_W-1:0] rd_slot;
  logic [STREAMS-1:0][7:0]        rd_byte;

  cm_entry_t cm_q [STREAMS][SLOTS];

  tsi_timing #(.SLOTS(SLOTS)) u_timing (
    .clk_i, .rst_ni, .fp_i,
    .bit_o(bit_idx), .slot_o(slot), .next_slot_o(next_slot),
    .slot_end_o(slot_end), .frame_end_o(frame_end), .page_o(page)
  );

  tsi_rx #(.STREAMS(STREAMS)) u_rx (
    .clk_i, .rst_ni, .sti_i, .byte_o(rx_byte)
  );

  tsi_dmem #(.STREAMS(STREAMS), .SLOTS(SLOTS)) u_dmem (
    .clk_i, .we_i(slot_end), .wr_page_i(page), .wr_slot_i(slot), .wr_byte_i(rx_byte),
    .rd_page_i(rd_page), .rd_str_i(rd_str), .rd_slot_i(rd_slot), .rd_byte_o(rd_byte)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STREAMS; s++)
        for (int t = 0; t < SLOTS; t++) cm_q[s][t] <= '0;
    end else if (cm_we_i) begin
      cm_q[cm_addr_i[AW-1:SLOT_W]][cm_addr_i[SLOT_W-1:0]] <= cm_entry_t'(cm_wdata_i);
    end
  end

  assign load = slot_end | frame_end;

  for (genvar o = 0; o < STREAMS; o++) begin : g_tx
    tsi_tx_lane #(.STREAMS(STREAMS), .SLOTS(SLOTS)) u_lane (
      .clk_i, .rst_ni, .oe_i,
      .load_i(load), .next_slot_i(next_slot), .cur_page_i(page), .bit_i(bit_idx),
      .entry_i(cm_q[o][next_slot]),
      .rd_page_o(rd_page[o]), .rd_str_o(rd_str[o]), .rd_slot_o(rd_slot[o]),
      .rd_byte_i(rd_byte[o]), .sto_o(sto_o[o]), .sto_en_o(sto_en_o[o])
    );
  end

  assert_oe_all_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oe_i |-> sto_en_o == '0) else $error("outputs driven while disabled");
endmodule

// File: tb/tsi_switch_core_test.sv
`timescale 1ns/100ps
module tsi_switch_core_test;
  localparam int SLOTS = 8;
  localparam int STREAMS = 4;
  localparam int FBITS = SLOTS * 8;
  localparam int NFRAMES = 31;

  logic clk = 1'b0, rst_n = 1'b0, fp = 1'b0, oe = 1'b1, cm_we = 1'b0;
  logic [STREAMS-1:0] sti = '0;
  logic [4:0]  cm_addr = '0;
  logic [10:0] cm_wdata = '0;
  logic [STREAMS-1:0] sto, sto_en;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  tsi_switch_core #(.GROUPS(1), .SLOTS(SLOTS)) uut (
    .clk_i(clk), .rst_ni(rst_n), .fp_i(fp), .sti_i(sti), .oe_i(oe),
    .cm_we_i(cm_we), .cm_addr_i(cm_addr), .cm_wdata_i(cm_wdata),
    .sto_o(sto), .sto_en_o(sto_en)
  );

  function automatic logic [7:0] din(int f, int i, int s);
    return 8'(f * 73 + i * 29 + s * 11 + 5);
  endfunction

  // control word {mode[10:9], const[8], payload[7:0]}; payload = {stream, slot[2:0]}
  function automatic logic [10:0] cfg(int p, int o, int t);
    logic [1:0] md;
    logic       cd;
    logic [7:0] pl;
    md = 2'd0; cd = 1'b0; pl = 8'd0;
    if (p < 8) begin
      case (o)
        0, 1: pl = 8'(((p % 4) << 3) | ((t + p) % 8));
        2: begin cd = 1'b1; pl = 8'((((2 + p) % 4) << 3) | ((t + p + 2) % 8)); end
        default: begin cd = 1'b1; pl = 8'((((3 + p) % 4) << 3) | ((t + p + 3) % 8)); end
      endcase
    end else begin
      case (o)
        0: begin md = 2'd1; pl = 8'(8'hA0 + t); end
        1: if (t % 2 == 0) md = 2'd2; else pl = 8'((2 << 3) | t);
        2: if (t == 3) md = 2'd3; else begin cd = 1'b1; pl = 8'((1 << 3) | (7 - t)); end
        default: pl = 8'(3 << 3);
      endcase
    end
    return {md, cd, pl};
  endfunction

  task automatic expect_slot(input int p, input int o, input int m, input int t,
                             output bit en, output logic [7:0] b, output string req);
    logic [10:0] w;
    int s, i;
    w = cfg(p, o, t);
    s = int'(w[2:0]);
    i = int'(w[4:3]);
    en = 1'b1; b = 8'd0; req = "R1";
    case (w[10:9])
      2'd0: begin
        if (w[8]) begin b = din(m - 2, i, s); req = (o == 3) ? "R1" : "R3"; end
        else begin
          b = (t > s) ? din(m, i, s) : din(m - 1, i, s);
          req = (o == 1 && p < 8) ? "R2" : ((p >= 8) ? "R9" : "R4");
        end
      end
      2'd1: begin b = w[7:0]; req = "R5"; end
      2'd2: begin b = 8'hFF; req = "R6"; end
      default: begin en = 1'b0; req = "R7"; end
    endcase
    if (p == 9) begin en = 1'b0; req = "R8"; end
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  initial begin
    int p, sub;
    logic [7:0] obs [STREAMS];
    bit en_all [STREAMS];
    bit en_any [STREAMS];
    logic [7:0] ib;
    bit e_en;
    logic [7:0] e_b;
    string req;

    repeat (3) @(posedge clk);
    #1;
    check(sto_en == '0, "R10", int'(sto_en), 0);
    check(sto == '0, "R10", int'(sto), 0);
    rst_n = 1'b1;
    @(posedge clk);
    #1 fp = 1'b1;
    for (int o = 0; o < STREAMS; o++) begin obs[o] = '0; en_all[o] = 1'b1; en_any[o] = 1'b0; end

    for (int fr = 0; fr < NFRAMES; fr++) begin
      p   = (fr == 0) ? -1 : (fr - 1) / 3;
      sub = (fr == 0) ? 0 : (fr - 1) % 3;
      for (int pos = 0; pos < FBITS; pos++) begin
        @(posedge clk);
        #1;
        fp = (pos == FBITS - 1);
        for (int i = 0; i < STREAMS; i++) begin
          ib = din(fr, i, pos / 8);
          sti[i] = ib[7 - pos % 8];
        end
        cm_we    = (sub == 0 && p >= 0 && pos < 32);
        cm_addr  = 5'(pos);
        cm_wdata = cfg(p, (pos / 8) % 4, pos % 8);
        oe       = !(p == 9 && sub != 0);
        #2;
        for (int o = 0; o < STREAMS; o++) begin
          obs[o] = {obs[o][6:0], sto[o]};
          en_all[o] &= sto_en[o];
          en_any[o] |= sto_en[o];
        end
        if (pos % 8 == 7) begin
          if (p >= 0 && sub != 0) begin
            for (int o = 0; o < STREAMS; o++) begin
              expect_slot(p, o, fr, pos / 8, e_en, e_b, req);
              if (e_en) check(en_all[o] && obs[o] == e_b, req,
                              int'({en_all[o], obs[o]}), int'({1'b1, e_b}));
              else      check(!en_any[o], req, int'(en_any[o]), 0);
            end
          end
          for (int o = 0; o < STREAMS; o++) begin obs[o] = '0; en_all[o] = 1'b1; en_any[o] = 1'b0; end
        end
      end
    end
    @(posedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule